// File: doc/BRIEF.md
# Trigger and Sweep Activity Status Encoder

This block condenses five trigger-related conditions into one status byte that a controller collects through a poll pulse. Four active-low pins are watched: the A and B sweep gates and the A and B trigger signals. Each pin passes through a synchronizer. The block then records any activity on those pins between two polls. A single-sweep ready flag supplies the last bit of the byte.

The A sweep gate and both trigger signals each get a 2-bit field. The field tells the reader one of three things: the pin is low now, the pin is high now, or the pin moved at some point since the previous poll. The B sweep gate gets a single sticky bit instead. That bit reports whether the gate was low at any time since the last poll.

Each poll pulse loads a fresh byte into the output register. The same pulse clears the activity history, so every report covers exactly one poll interval. The byte then stays unchanged until the next poll.

Top module: `trig_status_enc`

## Requirements
- R1: After reset the status byte reads 0x55. This is the value for all pins high, no activity, and ready set.
- R2: The bit positions are fixed. Bit 7 is the B sweep gate flag, bits 6:5 are the A sweep gate field, bits 4:3 are the B trigger field, bits 2:1 are the A trigger field, and bit 0 is ready. A 2-bit field never reads 00.
- R3: With no transition since the previous poll, a field reads 01 when its pin is low and 10 when its pin is high.
- R4: A field reads 11 when its pin changed level at any time since the previous poll. This includes a pulse that returned to its starting level before the poll.
- R5: The 11 code lasts for one poll only. If no further transition occurs, the next poll shows the live level again.
- R6: Bit 7 reads 1 in two cases: the B sweep gate was low at any time since the previous poll, or it is low at poll time. Bit 7 reads 0 only if the gate stayed high throughout.
- R7: When single-sweep mode is not selected, bit 0 reads 1, whatever the ready flag holds.
- R8: In single-sweep mode, bit 0 reads the ready flag.
  - A sweep-done pulse clears the flag.
  - An arm pulse sets the flag.
  - When arm and sweep done occur in the same cycle, arm wins.
  - A sweep-done pulse outside single-sweep mode leaves the flag set.
- R9: The status byte changes only on the clock edge where the poll pulse is high. It holds its value between polls even when the pins move.
- R10: A pin transition is detected by the synchronized edge detector in the same cycle that a poll is captured. That transition is reported as 11 in that poll and is not carried into the next one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sweepGateAN | input | 1 | A sweep gate, active low, asynchronous |
| sweepGateBN | input | 1 | B sweep gate, active low, asynchronous |
| trigAN | input | 1 | A trigger, active low, asynchronous |
| trigBN | input | 1 | B trigger, active low, asynchronous |
| pollStrobe | input | 1 | One-cycle pulse that captures the byte and clears the history |
| singleMode | input | 1 | Single-sweep mode selected |
| armSingle | input | 1 | Arm pulse; sets the ready flag |
| sweepDone | input | 1 | Sweep completion pulse |
| statusByte | output | 8 | Captured status byte |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is a synchronized pin edge and a poll capture. The bench changes a trigger pin, waits two clock edges, and raises the poll pulse so that its capture edge matches the edge-detector cycle. The captured field must read 11. The following poll must show the plain low code, which proves that the transition was neither lost nor reported twice.

The second pair is arm and sweep done, asserted together in single-sweep mode. The bench judges this case by bit 0 of the next poll, which must read 1.

// File: rtl/trig_status_pkg.sv
package trig_status_pkg;

  localparam int NUM_PINS       = 4;
  localparam int NUM_FIELD_PINS = 3;

  // pin index order inside the block
  localparam int PIN_TRIG_A = 0;
  localparam int PIN_TRIG_B = 1;
  localparam int PIN_GATE_A = 2;
  localparam int PIN_GATE_B = 3;

  localparam logic [1:0] CODE_LOW     = 2'b01;
  localparam logic [1:0] CODE_HIGH    = 2'b10;
  localparam logic [1:0] CODE_TOGGLED = 2'b11;

  // all pins high, no activity, ready
  localparam logic [7:0] STATUS_IDLE = 8'h55;

  typedef struct packed {
    logic capture;
    logic clearHist;
    logic readyBit;
  } ctrl_t;

endpackage

// File: rtl/trig_status_ctrl.sv
module trig_status_ctrl
  import trig_status_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  pollStrobe,
  input  logic  singleMode,
  input  logic  armSingle,
  input  logic  sweepDone,
  output ctrl_t ctrl
);

  logic readyFlag;

  // arm has priority over a completion in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      readyFlag <= 1'b1;
    else if (armSingle)
      readyFlag <= 1'b1;
    else if (singleMode && sweepDone)
      readyFlag <= 1'b0;
  end

  always_comb begin
    ctrl.capture   = pollStrobe;
    ctrl.clearHist = pollStrobe;
    ctrl.readyBit  = !singleMode || readyFlag;
  end

  // R8: a completion in single mode without arm drops readiness
  a_r8_done_clears: assert property (@(posedge clk) disable iff (!rstN)
    (singleMode && sweepDone && !armSingle) |=> !readyFlag);

  // R8: arm always leaves the flag set
  a_r8_arm_sets: assert property (@(posedge clk) disable iff (!rstN)
    armSingle |=> readyFlag);

  // R8: without single mode a completion never clears readiness
  a_r8_other_mode_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (!singleMode && $past(readyFlag) == 1'b1 && readyFlag == 1'b1) |=> (singleMode || readyFlag));

endmodule

// File: rtl/trig_status_datapath.sv
module trig_status_datapath
  import trig_status_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinsN,
  input  ctrl_t               ctrl,
  output logic [7:0]          statusByte
);

  logic [NUM_PINS-1:0]       syncN;
  logic [NUM_FIELD_PINS-1:0] prevN;
  logic [NUM_FIELD_PINS-1:0] edgeHit;
  logic [NUM_FIELD_PINS-1:0] toggleHist;
  logic [NUM_FIELD_PINS-1:0] toggleSeen;
  logic                      lowSeenB;
  logic [7:0]                nextByte;

  // synchronizer chain per pin; idle level is high
  for (genvar g = 0; g < NUM_PINS; g++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '1;
      else       chain <= {chain[SYNC_STAGES-2:0], pinsN[g]};
    end
    assign syncN[g] = chain[SYNC_STAGES-1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevN <= '1;
    else       prevN <= syncN[NUM_FIELD_PINS-1:0];
  end

  assign edgeHit    = syncN[NUM_FIELD_PINS-1:0] ^ prevN;
  assign toggleSeen = toggleHist | edgeHit;

  // history for one poll interval; the poll cycle's own edge goes into the captured word
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      toggleHist <= '0;
      lowSeenB   <= 1'b0;
    end else if (ctrl.clearHist) begin
      toggleHist <= '0;
      lowSeenB   <= 1'b0;
    end else begin
      toggleHist <= toggleSeen;
      lowSeenB   <= lowSeenB | ~syncN[PIN_GATE_B];
    end
  end

  function automatic logic [1:0] fieldCode(input logic seen, input logic levelN);
    if (seen)        return CODE_TOGGLED;
    else if (levelN) return CODE_HIGH;
    else             return CODE_LOW;
  endfunction

  always_comb begin
    nextByte[7]   = lowSeenB | ~syncN[PIN_GATE_B];
    nextByte[6:5] = fieldCode(toggleSeen[PIN_GATE_A], syncN[PIN_GATE_A]);
    nextByte[4:3] = fieldCode(toggleSeen[PIN_TRIG_B], syncN[PIN_TRIG_B]);
    nextByte[2:1] = fieldCode(toggleSeen[PIN_TRIG_A], syncN[PIN_TRIG_A]);
    nextByte[0]   = ctrl.readyBit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             statusByte <= STATUS_IDLE;
    else if (ctrl.capture) statusByte <= nextByte;
  end

  // R9: no poll, no change
  a_r9_hold_between_polls: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.capture |=> $stable(statusByte));

  // R2: no field ever carries the unused code
  a_r2_codes_legal: assert property (@(posedge clk) disable iff (!rstN)
    (statusByte[6:5] != 2'b00) && (statusByte[4:3] != 2'b00) && (statusByte[2:1] != 2'b00));

  // R6: a low B gate at capture is always reported
  a_r6_gate_b_low: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.capture && !syncN[PIN_GATE_B]) |=> statusByte[7]);

  // R5: a toggled report on trigger A is not repeated without a new edge
  a_r5_one_poll: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.capture && statusByte[2:1] == CODE_TOGGLED && !toggleSeen[PIN_TRIG_A])
      |=> (statusByte[2:1] != CODE_TOGGLED));

endmodule

// File: rtl/trig_status_enc.sv
module trig_status_enc
  import trig_status_pkg::*;
#(
  parameter int SYNC_STAGES = 2
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sweepGateAN,
  input  logic       sweepGateBN,
  input  logic       trigAN,
  input  logic       trigBN,
  input  logic       pollStrobe,
  input  logic       singleMode,
  input  logic       armSingle,
  input  logic       sweepDone,
  output logic [7:0] statusByte
);

  ctrl_t               ctrl;
  logic [NUM_PINS-1:0] pinsN;

  always_comb begin
    pinsN[PIN_TRIG_A] = trigAN;
    pinsN[PIN_TRIG_B] = trigBN;
    pinsN[PIN_GATE_A] = sweepGateAN;
    pinsN[PIN_GATE_B] = sweepGateBN;
  end

  trig_status_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pollStrobe (pollStrobe),
    .singleMode (singleMode),
    .armSingle  (armSingle),
    .sweepDone  (sweepDone),
    .ctrl       (ctrl)
  );

  trig_status_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .pinsN      (pinsN),
    .ctrl       (ctrl),
    .statusByte (statusByte)
  );

endmodule

// File: tb/trig_status_enc_bench.sv
module trig_status_enc_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG_CYCLES = 5000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sweepGateAN = 1'b1;
  logic       sweepGateBN = 1'b1;
  logic       trigAN = 1'b1;
  logic       trigBN = 1'b1;
  logic       pollStrobe = 1'b0;
  logic       singleMode = 1'b0;
  logic       armSingle = 1'b0;
  logic       sweepDone = 1'b0;
  logic [7:0] statusByte;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_status_enc u_trig_status_enc (
    .clk(clk), .rstN(rstN),
    .sweepGateAN(sweepGateAN), .sweepGateBN(sweepGateBN),
    .trigAN(trigAN), .trigBN(trigBN),
    .pollStrobe(pollStrobe), .singleMode(singleMode),
    .armSingle(armSingle), .sweepDone(sweepDone),
    .statusByte(statusByte)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic doPoll();
    @(negedge clk) pollStrobe = 1'b1;
    @(negedge clk) pollStrobe = 1'b0;
  endtask

  task automatic pulseCtrl(input logic arm, input logic done);
    @(negedge clk);
    armSingle = arm;
    sweepDone = done;
    @(negedge clk);
    armSingle = 1'b0;
    sweepDone = 1'b0;
  endtask

  task automatic testReset();
    check("R1 reset byte", statusByte, 8'h55);
    doPoll();
    check("R3 idle poll all high", statusByte, 8'h55);
  endtask

  task automatic testHeldLow();
    trigAN = 1'b0;
    idle(5);
    doPoll();
    check("R4 trigger A went low", statusByte, 8'h57);
    idle(3);
    doPoll();
    check("R5 trigger A live low after toggle", statusByte, 8'h53);
    sweepGateAN = 1'b0;
    trigAN = 1'b1;
    idle(5);
    doPoll();
    check("R2 gate A and trigger A both toggled", statusByte, 8'h77);
    doPoll();
    check("R3 gate A live low", statusByte, 8'h35);
    sweepGateAN = 1'b1;
    idle(5);
    doPoll();
    doPoll();
    check("R3 back to idle", statusByte, 8'h55);
  endtask

  task automatic testPulse();
    @(negedge clk) trigBN = 1'b0;
    idle(3);
    trigBN = 1'b1;
    idle(5);
    doPoll();
    check("R4 trigger B pulse returned high", statusByte, 8'h5D);
    doPoll();
    check("R5 trigger B pulse not repeated", statusByte, 8'h55);
  endtask

  task automatic testGateB();
    @(negedge clk) sweepGateBN = 1'b0;
    idle(3);
    sweepGateBN = 1'b1;
    idle(5);
    doPoll();
    check("R6 gate B pulse low seen", statusByte, 8'hD5);
    doPoll();
    check("R6 gate B stayed high", statusByte, 8'h55);
    sweepGateBN = 1'b0;
    idle(5);
    doPoll();
    idle(4);
    doPoll();
    check("R6 gate B still low at poll", statusByte, 8'hD5);
    sweepGateBN = 1'b1;
    idle(5);
    doPoll();
    doPoll();
    check("R6 gate B high again", statusByte, 8'h55);
  endtask

  task automatic testHold();
    trigAN = 1'b0;
    sweepGateBN = 1'b0;
    idle(8);
    check("R9 byte holds without poll", statusByte, 8'h55);
    trigAN = 1'b1;
    sweepGateBN = 1'b1;
    idle(5);
    check("R9 byte still holds", statusByte, 8'h55);
    doPoll();
    doPoll();
  endtask

  task automatic testReady();
    pulseCtrl(1'b0, 1'b1);
    doPoll();
    check("R7 done outside single mode", statusByte, 8'h55);
    @(negedge clk) singleMode = 1'b1;
    doPoll();
    check("R8 single mode still ready", statusByte, 8'h55);
    pulseCtrl(1'b0, 1'b1);
    doPoll();
    check("R8 done clears ready", statusByte, 8'h54);
    @(negedge clk) singleMode = 1'b0;
    doPoll();
    check("R7 other mode reads one", statusByte, 8'h55);
    @(negedge clk) singleMode = 1'b1;
    doPoll();
    check("R8 flag still clear", statusByte, 8'h54);
    pulseCtrl(1'b1, 1'b0);
    doPoll();
    check("R8 arm sets ready", statusByte, 8'h55);
    pulseCtrl(1'b1, 1'b1);
    doPoll();
    check("R8 arm wins over done", statusByte, 8'h55);
    @(negedge clk) singleMode = 1'b0;
  endtask

  task automatic testSameCycle();
    // pin change, two sync edges, edge detector high while poll captures
    @(negedge clk) trigBN = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk) pollStrobe = 1'b1;
    @(negedge clk) pollStrobe = 1'b0;
    check("R10 edge in poll cycle reported", statusByte, 8'h5D);
    doPoll();
    check("R10 edge not carried forward", statusByte, 8'h4D);
    trigBN = 1'b1;
    idle(5);
    doPoll();
    doPoll();
    check("R10 restore idle", statusByte, 8'h55);
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    for (int i = 0; i < WATCHDOG_CYCLES; i++) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    testReset();
    testHeldLow();
    testPulse();
    testGateB();
    testHold();
    testReady();
    testSameCycle();
    report();
  end

endmodule